// File: doc/BRIEF.md
# Privilege-Tagged Direct-Mapped Instruction Cache

This block sits between an instruction fetch unit and external memory. It keeps 64 long-word lines, each holding two 16-bit instruction half-words. A fetch that hits returns a half-word from the line without an external cycle. A fetch that misses makes one long-word read from memory, returns the requested half and refills the whole line. Each stored tag carries the privilege bit of the function code next to the upper address bits. Supervisor code and user code at the same address are therefore kept apart.

The fetch side uses a request/acknowledge handshake. The requester holds `fetch_req`, `fetch_addr` and `fetch_fc` until it sees a one-cycle `fetch_ack`. It then drops `fetch_req` for at least one cycle. The memory side works the same way: the cache holds `mem_req` and `mem_addr` until memory returns a one-cycle `mem_ack` together with the long word. Only code-space fetches use the cache. Data-space accesses, and all accesses made while the enable input is low, go straight to memory.

Top module: `icache_top`

## Requirements
- R1: Reset clears every line's valid flag and holds `fetch_ack` and `mem_req` low. The first cacheable fetch after reset misses, even at an address that was cached before the reset.
- R2: The line is chosen by address bits 7..2. The stored tag is address bits 31..8 plus function-code bit 2. A hit needs the valid flag set and both parts of the tag to match.
- R3: On a hit, `fetch_ack` is high for exactly one cycle, in the clock cycle after the one in which `fetch_req` is first sampled. No memory request is made.
- R4: Address bit 1 picks the returned half of the 32-bit line: 1 gives bits 31..16 and 0 gives bits 15..0. The same rule applies to data coming from memory on a miss.
- R5: On a miss, `mem_req` is raised with `mem_addr` set to the fetch address with bits 1..0 cleared. Both stay stable until `mem_ack`. `fetch_ack` is asserted in the same cycle as `mem_ack`, so a miss takes one cycle plus the memory latency.
- R6: A refill writes the whole long word, so a later fetch of the other half of the same line hits.
- R7: A user fetch (function-code bit 2 = 0) and a supervisor fetch (bit 2 = 1) to the same address never hit on each other's line. Each one refills the line it shares with the other.
- R8: Only function codes whose low two bits are 2'b10 are cached. Any other code always goes to memory and neither reads nor writes a line, so a cached line at the same index stays valid.
- R9: While `cache_en` is low, every fetch goes to memory. Lines are neither read nor written. After `cache_en` returns high, lines loaded earlier still hit with their old contents.
- R10: Two cacheable addresses with the same index but different tags replace each other in that single line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Cache enable; low forces every fetch to memory |
| fetch_req | input | 1 | Fetch request, held until `fetch_ack` |
| fetch_addr | input | 32 | Byte address of the half-word to fetch |
| fetch_fc | input | 3 | Function code: bit 2 = supervisor, bits 1..0 = space (2'b10 = code) |
| fetch_ack | output | 1 | One-cycle completion of a fetch |
| fetch_data | output | 16 | Returned half-word, valid while `fetch_ack` is high |
| mem_req | output | 1 | External long-word read request |
| mem_addr | output | 32 | Long-word-aligned external address |
| mem_ack | input | 1 | External read completion, one cycle |
| mem_rdata | input | 32 | External long word, valid with `mem_ack` |

## Verification
If a valid flag or tag is stored wrongly, the effect shows at the ports on the next fetch to that index. A line that should be resident instead raises `mem_req` and takes the miss latency. A line that should have been evicted instead returns stale data with `fetch_ack` a single cycle after the request. If the half-select or the refill path is wrong, `fetch_data` is wrong in the same cycle as `fetch_ack`, or on the first later hit to the other half. The bench counts memory transactions and fetch latency per access, and gives memory contents a generation value. This lets it tell a fresh refill apart from a stale line held across a disabled period.

// File: rtl/icache_pkg.sv
package icache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_FILL
    } fsm_e;

    localparam logic [1:0] SPACE_CODE = 2'b10;

endpackage

// File: rtl/icache_store.sv
module icache_store #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 25,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_word
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  valid_d, valid_q;
    logic [TAG_W-1:0]  tag_mem  [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_word;
        end
    end

    assign rd_hit  = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
    assign rd_word = data_mem[rd_idx];

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32,
    parameter int FC_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cache_en,
    input  logic                 fetch_req,
    input  logic [ADDR_W-1:0]    fetch_addr,
    input  logic [FC_W-1:0]      fetch_fc,
    output logic                 fetch_ack,
    output logic [DATA_W/2-1:0]  fetch_data,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_ack,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [IDX_W-1:0]     lk_idx,
    output logic [ADDR_W-IDX_W-$clog2(DATA_W/8):0] lk_tag,
    input  logic                 lk_hit,
    input  logic [DATA_W-1:0]    lk_word,
    output logic                 fill_we
);
    localparam int OFF_W  = $clog2(DATA_W/8);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        fsm_e              st;
        logic [ADDR_W-1:0] addr;
        logic [FC_W-1:0]   fc;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    logic cacheable;
    logic sel_hi;
    logic unused_lsb;

    assign unused_lsb = ^ctx_q.addr[OFF_W-2:0];
    assign cacheable  = cache_en && (ctx_q.fc[1:0] == SPACE_CODE);
    assign sel_hi     = ctx_q.addr[OFF_W-1];
    assign lk_idx     = ctx_q.addr[OFF_W +: IDX_W];
    assign lk_tag     = {ctx_q.fc[FC_W-1], ctx_q.addr[ADDR_W-1:IDX_W+OFF_W]};
    assign mem_addr   = {ctx_q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    always_comb begin
        ctx_d      = ctx_q;
        fetch_ack  = 1'b0;
        fetch_data = '0;
        mem_req    = 1'b0;
        fill_we    = 1'b0;
        case (ctx_q.st)
            ST_IDLE: begin
                if (fetch_req) begin
                    ctx_d.addr = fetch_addr;
                    ctx_d.fc   = fetch_fc;
                    ctx_d.st   = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (cacheable && lk_hit) begin
                    fetch_ack  = 1'b1;
                    fetch_data = sel_hi ? lk_word[DATA_W-1:HALF_W] : lk_word[HALF_W-1:0];
                    ctx_d.st   = ST_IDLE;
                end else begin
                    ctx_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fetch_ack  = 1'b1;
                    fetch_data = sel_hi ? mem_rdata[DATA_W-1:HALF_W] : mem_rdata[HALF_W-1:0];
                    fill_we    = cacheable;
                    ctx_d.st   = ST_IDLE;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q.st   <= ST_IDLE;
            ctx_q.addr <= '0;
            ctx_q.fc   <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

endmodule

// File: rtl/icache_top.sv
module icache_top #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32,
    parameter int FC_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cache_en,
    input  logic                fetch_req,
    input  logic [ADDR_W-1:0]   fetch_addr,
    input  logic [FC_W-1:0]     fetch_fc,
    output logic                fetch_ack,
    output logic [DATA_W/2-1:0] fetch_data,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int OFF_W = $clog2(DATA_W/8);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W + 1;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_word;
    logic              fill_we;

    icache_ctrl #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .FC_W(FC_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cache_en  (cache_en),
        .fetch_req (fetch_req),
        .fetch_addr(fetch_addr),
        .fetch_fc  (fetch_fc),
        .fetch_ack (fetch_ack),
        .fetch_data(fetch_data),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .lk_idx    (lk_idx),
        .lk_tag    (lk_tag),
        .lk_hit    (lk_hit),
        .lk_word   (lk_word),
        .fill_we   (fill_we)
    );

    icache_store #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_idx),
        .rd_tag (lk_tag),
        .rd_hit (lk_hit),
        .rd_word(lk_word),
        .wr_en  (fill_we),
        .wr_idx (lk_idx),
        .wr_tag (lk_tag),
        .wr_word(mem_rdata)
    );

endmodule

// File: rtl/icache_chk.sv
module icache_chk #(
    parameter int ADDR_W = 32,
    parameter int FC_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cache_en,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [FC_W-1:0]   fetch_fc,
    input logic              fetch_ack,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ack |=> !fetch_ack); // R3
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ack |-> fetch_req); // R3
    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R5
    AST_FILL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == {fetch_addr[ADDR_W-1:2], 2'b00})); // R5
    AST_FILL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> fetch_req); // R5
    AST_UNCACHED_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ack && fetch_fc[1:0] != 2'b10) |-> mem_ack); // R8
    AST_DISABLED_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ack && !cache_en) |-> mem_ack); // R9
endmodule

bind icache_top icache_chk #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cache_en  (cache_en),
    .fetch_req (fetch_req),
    .fetch_addr(fetch_addr),
    .fetch_fc  (fetch_fc),
    .fetch_ack (fetch_ack),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack)
);

// File: tb/tb_icache_top.sv
`timescale 1ns/1ps
module tb_icache_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [2:0]  fetch_fc = '0;
    logic        fetch_ack;
    logic [15:0] fetch_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int mem_cnt = 0;
    int lat = 2;
    int lat_cnt = 0;
    logic [15:0] gen = 16'h0000;
    bit done = 0;

    always #5 clk = ~clk;

    icache_top dut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_fc(fetch_fc),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a, input logic [15:0] g);
        return {a[17:2] ^ 16'hC3A5 ^ g, a[25:10] ^ 16'h1E0F ^ g};
    endfunction

    function automatic logic [15:0] half_of(input logic [31:0] a, input logic [15:0] g);
        logic [31:0] w;
        w = word_of(a, g);
        return a[1] ? w[31:16] : w[15:0];
    endfunction

    // external memory model
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            lat_cnt++;
            if (lat_cnt >= lat) begin
                mem_ack   = 1'b1;
                mem_rdata = word_of(mem_addr, gen);
                lat_cnt   = 0;
                mem_cnt++;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [31:0] a, input logic [2:0] fc,
                            output logic [15:0] d, output int cyc, output int nmem);
        int m0;
        m0 = mem_cnt;
        fetch_addr = a;
        fetch_fc   = fc;
        fetch_req  = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk); #1;
            cyc++;
        end while (!fetch_ack && cyc < 100);
        d = fetch_data;
        @(posedge clk); #1;
        fetch_req = 1'b0;
        nmem = mem_cnt - m0;
        @(negedge clk); #1;
    endtask

    task automatic access(input string tag, input logic [31:0] a, input logic [2:0] fc,
                          input bit miss, input logic [15:0] exp_d);
        logic [15:0] d;
        int cyc, nmem;
        do_fetch(a, fc, d, cyc, nmem);
        check({tag, " data"}, {16'h0, d}, {16'h0, exp_d});
        check({tag, " mem count"}, nmem, miss ? 1 : 0);
        check({tag, " latency"}, cyc, miss ? 1 + lat : 1);
    endtask

    // {address, function code, expect miss}
    localparam logic [35:0] VEC [0:15] = '{
        {32'h0000_1000, 3'd6, 1'b1},  // R1 R5 cold miss, R4 low half
        {32'h0000_1002, 3'd6, 1'b0},  // R6 R3 other half hits, R4 high half
        {32'h0000_1000, 3'd2, 1'b1},  // R7 user misses on supervisor line
        {32'h0000_1002, 3'd6, 1'b1},  // R7 supervisor evicted by user
        {32'h0000_2000, 3'd6, 1'b1},  // R10 same index, other tag
        {32'h0000_1002, 3'd6, 1'b1},  // R10 replaced again
        {32'h0000_1044, 3'd6, 1'b1},  // R2 index 17
        {32'h0000_1046, 3'd6, 1'b0},  // R3 R2 hit
        {32'h0000_1044, 3'd5, 1'b1},  // R8 data space bypass
        {32'h0000_1046, 3'd5, 1'b1},  // R8 not cached
        {32'h0000_1046, 3'd6, 1'b0},  // R8 line kept valid
        {32'hFFFF_FFFC, 3'd6, 1'b1},  // R2 top of address space
        {32'hFFFF_FFFE, 3'd6, 1'b0},  // R4 R6 top half hit
        {32'h0000_1044, 3'd1, 1'b1},  // R8 user data bypass
        {32'h0000_1044, 3'd6, 1'b0},  // R8 still hits
        {32'h0000_1000, 3'd2, 1'b1}   // R7 user line was replaced
    };

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int cyc, nmem;
        repeat (3) @(negedge clk);
        #1;
        check("R1 ack idle in reset", {31'h0, fetch_ack}, 32'h0);
        check("R1 mem_req idle in reset", {31'h0, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 ack idle after reset", {31'h0, fetch_ack}, 32'h0);
        check("R1 mem_req idle after reset", {31'h0, mem_req}, 32'h0);

        for (int i = 0; i < 16; i++) begin
            access($sformatf("vec %0d", i), VEC[i][35:4], VEC[i][3:1], VEC[i][0],
                   half_of(VEC[i][35:4], gen));
        end

        // R1: reset drops the valid line at index 17
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        access("R1 miss after reset", 32'h0000_1046, 3'd6, 1'b1, half_of(32'h0000_1046, 16'h0));

        // R9: disabled cache neither reads nor writes
        gen = 16'h5A5A;
        cache_en = 1'b0;
        access("R9 disabled fetch of resident line", 32'h0000_1044, 3'd6, 1'b1,
               half_of(32'h0000_1044, 16'h5A5A));
        access("R9 disabled fetch of new line", 32'h0000_1080, 3'd6, 1'b1,
               half_of(32'h0000_1080, 16'h5A5A));
        cache_en = 1'b1;
        access("R9 old line intact", 32'h0000_1044, 3'd6, 1'b0, half_of(32'h0000_1044, 16'h0));
        access("R9 no fill while disabled", 32'h0000_1080, 3'd6, 1'b1,
               half_of(32'h0000_1080, 16'h5A5A));

        // R5: long memory latency stalls the fetch
        lat = 5;
        do_fetch(32'h0000_3002, 3'd6, d, cyc, nmem);
        check("R5 stalled data", {16'h0, d}, {16'h0, half_of(32'h0000_3002, gen)});
        check("R5 stalled latency", cyc, 6);
        check("R5 single memory read", nmem, 1);
        access("R6 R3 hit after stalled fill", 32'h0000_3000, 3'd6, 1'b0,
               half_of(32'h0000_3000, gen));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule